// File: doc/BRIEF.md
# UART Interrupt Status Encoder with Flow-Control Sources

This block forms the interrupt identification byte of one UART channel. It watches seven interrupt causes. Three of them are level inputs kept by the surrounding channel: line error, receive data available and receive timeout. Four are latched here from single-cycle pulses: transmit holding empty, modem status change, flow-character match and flow-signal rising edge. The block reports the most urgent enabled cause as a fixed code. It drives a registered interrupt request. It also records whether the last flow character matched was the stop or the resume character.

The same block owns the FIFO-control write path. That path covers the FIFO enable bit, a stored receive trigger field and a block-mode bit. It also issues a one-cycle reset pulse for the receive FIFO pointers when software asks for one. The reset pulse does not reach the receive shift register. The channel's bus decoder drives `isr_rd` when the status byte is read and `fcr_wr` when the control byte is written.

Top module: `uart_irq_status`

## Requirements
- R1: After reset `isr_out` is 0x01, `irq` is 0, `fifo_en` is 0 and `rx_fifo_rst` is 0.
- R2: Bit 0 of `isr_out` is 0 while any enabled cause is pending. Bits 5:0 then hold the code of the highest one, in falling priority: line error 0x06, receive data 0x04, receive timeout 0x0C, transmit empty 0x02, modem change 0x00, flow character 0x10, flow-signal rise 0x20. With nothing pending, bits 5:0 read 0x01.
- R3: A cause whose bit in `src_en` is 0 never shows in the code. The `src_en` bits are: bit 0 line error, bit 1 receive data and timeout, bit 2 transmit empty, bit 3 modem, bit 4 flow character, bit 5 flow-signal rise.
- R4: Codes 0x10 and 0x20 appear only while `enh_en` is 1. An event latched while `enh_en` is 0 stays pending and shows once `enh_en` is set.
- R5: A status read (`isr_rd`) clears the transmit-empty or modem latch only when that cause is the one being reported in that cycle.
- R6: A stop or resume character match raises code 0x10, which a status read reporting it clears. `xoff_last` is 1 after a stop match and 0 after a resume match.
- R7: A special-character match raises code 0x10. It clears on a status read reporting it, or when `rx_char_done` pulses.
- R8: Code 0x20 is raised only by a low-to-high change of `flow_sig`. A steady level or a falling edge raises nothing.
- R9: `isr_out[7:6]` reads 2'b11 while `fifo_en` is 1 and 2'b00 otherwise.
- R10: An `fcr_wr` loads `fifo_en` from `fcr_wdata[0]`. The receive trigger (`fcr_wdata[7:6]`) and block mode (`fcr_wdata[3]`) are loaded only when `fcr_wdata[0]` is 1 in that same write.
- R11: A write with `fcr_wdata[1:0]` = 2'b11 makes `rx_fifo_rst` high for exactly the one cycle after the write.
- R12: `irq` equals the inverse of `isr_out[0]` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_err | input | 1 | Line error condition (level) |
| rx_ready | input | 1 | Receive data available (level) |
| rx_timeout | input | 1 | Receive character timeout (level) |
| ev_thr_empty | input | 1 | Transmit holding became empty (pulse) |
| ev_modem | input | 1 | Modem input changed (pulse) |
| ev_xon | input | 1 | Resume character matched (pulse) |
| ev_xoff | input | 1 | Stop character matched (pulse) |
| ev_special | input | 1 | Special character matched (pulse) |
| rx_char_done | input | 1 | A character was received (pulse) |
| flow_sig | input | 1 | Monitored flow-control signal |
| src_en | input | 6 | Per-cause enables |
| enh_en | input | 1 | Enables the two flow-control codes |
| isr_rd | input | 1 | Status byte read strobe |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_wdata | input | 8 | FIFO-control write data |
| isr_out | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request |
| xoff_last | output | 1 | Last flow character was the stop character |
| fifo_en | output | 1 | FIFOs enabled |
| rx_trig | output | 2 | Stored receive trigger field |
| blk_mode | output | 1 | Stored block-transfer mode bit |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO pointer reset |

## Verification
The bench walks the whole priority ladder by removing causes one at a time. An encoder with two levels swapped would report the wrong code on one step. It reads the status byte while a higher cause hides the transmit-empty latch. A design that clears on every read would then lose that event. It holds `flow_sig` high across a read and then drops it, which catches level-sensitive detection or detection on the wrong edge. It writes FIFO-control bytes with bit 0 clear and checks that the trigger field, the block-mode bit and the reset pulse are left alone. It also checks that the reset pulse lasts one cycle and that `irq` lags the status bit by exactly one clock.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int         SRC_N      = 6,
  parameter logic       FLOW_RST_Q = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_err,
  input  logic             rx_ready,
  input  logic             rx_timeout,
  input  logic             ev_thr_empty,
  input  logic             ev_modem,
  input  logic             ev_xon,
  input  logic             ev_xoff,
  input  logic             ev_special,
  input  logic             rx_char_done,
  input  logic             flow_sig,
  input  logic [SRC_N-1:0] src_en,
  input  logic             enh_en,
  input  logic             isr_rd,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_wdata,
  output logic [7:0]       isr_out,
  output logic             irq,
  output logic             xoff_last,
  output logic             fifo_en,
  output logic [1:0]       rx_trig,
  output logic             blk_mode,
  output logic             rx_fifo_rst
);

  localparam logic [5:0] C_LINE = 6'h06;
  localparam logic [5:0] C_RXD  = 6'h04;
  localparam logic [5:0] C_TMO  = 6'h0C;
  localparam logic [5:0] C_THR  = 6'h02;
  localparam logic [5:0] C_MSR  = 6'h00;
  localparam logic [5:0] C_XCH  = 6'h10;
  localparam logic [5:0] C_FLW  = 6'h20;
  localparam logic [5:0] C_NONE = 6'h01;

  logic thr_p, msr_p, xon_p, spc_p, flw_p, flow_q;
  logic [5:0] code;

  wire v_line = line_err   & src_en[0];
  wire v_rxd  = rx_ready   & src_en[1];
  wire v_tmo  = rx_timeout & src_en[1];
  wire v_thr  = thr_p      & src_en[2];
  wire v_msr  = msr_p      & src_en[3];
  wire v_xch  = (xon_p | spc_p) & src_en[4] & enh_en;
  wire v_flw  = flw_p      & src_en[5] & enh_en;
  wire flow_rise = flow_sig & ~flow_q;

  always_comb begin
    if      (v_line) code = C_LINE;
    else if (v_rxd)  code = C_RXD;
    else if (v_tmo)  code = C_TMO;
    else if (v_thr)  code = C_THR;
    else if (v_msr)  code = C_MSR;
    else if (v_xch)  code = C_XCH;
    else if (v_flw)  code = C_FLW;
    else             code = C_NONE;
  end

  wire rd_thr = isr_rd & (code == C_THR);
  wire rd_msr = isr_rd & (code == C_MSR);
  wire rd_xch = isr_rd & (code == C_XCH);
  wire rd_flw = isr_rd & (code == C_FLW);

  assign isr_out = {fifo_en, fifo_en, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_p     <= 1'b0;
      msr_p     <= 1'b0;
      xon_p     <= 1'b0;
      spc_p     <= 1'b0;
      flw_p     <= 1'b0;
      flow_q    <= FLOW_RST_Q;
      xoff_last <= 1'b0;
      irq       <= 1'b0;
    end else begin
      thr_p  <= ev_thr_empty | (thr_p & ~rd_thr);
      msr_p  <= ev_modem | (msr_p & ~rd_msr);
      xon_p  <= ev_xon | ev_xoff | (xon_p & ~rd_xch);
      spc_p  <= ev_special | (spc_p & ~rd_xch & ~rx_char_done);
      flw_p  <= flow_rise | (flw_p & ~rd_flw);
      flow_q <= flow_sig;
      if (ev_xoff)     xoff_last <= 1'b1;
      else if (ev_xon) xoff_last <= 1'b0;
      irq    <= ~isr_out[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en     <= 1'b0;
      rx_trig     <= 2'b00;
      blk_mode    <= 1'b0;
      rx_fifo_rst <= 1'b0;
    end else begin
      rx_fifo_rst <= fcr_wr & fcr_wdata[0] & fcr_wdata[1];
      if (fcr_wr) begin
        fifo_en <= fcr_wdata[0];
        if (fcr_wdata[0]) begin
          rx_trig  <= fcr_wdata[7:6];
          blk_mode <= fcr_wdata[3];
        end
      end
    end
  end

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    isr_out[0] |-> isr_out[5:0] == C_NONE); // R2
  AST_MASK_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en[0] |-> isr_out[5:0] != C_LINE); // R3
  AST_ENH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |-> isr_out[5:4] == 2'b00); // R4
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flw_p) |-> $past(flow_sig)); // R8
  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    isr_out[7] == isr_out[6]); // R9
  AST_FCR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && !fcr_wdata[0]) |=> $stable(rx_trig) && $stable(blk_mode)); // R10
  AST_RST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_rst |=> !rx_fifo_rst); // R11
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_out[0] |=> irq); // R12

endmodule

// File: tb/test_uart_irq_status.sv
module test_uart_irq_status;
  logic clk = 0, rst_n = 0;
  logic line_err = 0, rx_ready = 0, rx_timeout = 0;
  logic ev_thr_empty = 0, ev_modem = 0, ev_xon = 0, ev_xoff = 0, ev_special = 0;
  logic rx_char_done = 0, flow_sig = 0, enh_en = 0, isr_rd = 0, fcr_wr = 0;
  logic [5:0] src_en = 0;
  logic [7:0] fcr_wdata = 0;
  logic [7:0] isr_out;
  logic irq, xoff_last, fifo_en, blk_mode, rx_fifo_rst;
  logic [1:0] rx_trig;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_irq_status i_uart_irq_status (
    .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .ev_thr_empty(ev_thr_empty), .ev_modem(ev_modem),
    .ev_xon(ev_xon), .ev_xoff(ev_xoff), .ev_special(ev_special),
    .rx_char_done(rx_char_done), .flow_sig(flow_sig), .src_en(src_en),
    .enh_en(enh_en), .isr_rd(isr_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .isr_out(isr_out), .irq(irq), .xoff_last(xoff_last), .fifo_en(fifo_en),
    .rx_trig(rx_trig), .blk_mode(blk_mode), .rx_fifo_rst(rx_fifo_rst));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd();
    isr_rd = 1; tick(); isr_rd = 0;
  endtask

  task automatic fcr(logic [7:0] d);
    fcr_wr = 1; fcr_wdata = d; tick(); fcr_wr = 0; fcr_wdata = 0;
  endtask

  task automatic t_reset();
    chk("R1 isr", isr_out, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 fifo_en", fifo_en, 0);
    chk("R1 rst", rx_fifo_rst, 0);
  endtask

  task automatic t_priority();
    src_en = 6'h3F; enh_en = 1;
    line_err = 1; rx_ready = 1; rx_timeout = 1;
    ev_thr_empty = 1; ev_modem = 1; ev_xon = 1; flow_sig = 1;
    tick();
    ev_thr_empty = 0; ev_modem = 0; ev_xon = 0;
    chk("R2 line", isr_out, 8'h06);
    line_err = 0; tick(); chk("R2 rxd", isr_out, 8'h04);
    rx_ready = 0; tick(); chk("R2 tmo", isr_out, 8'h0C);
    rx_timeout = 0; tick(); chk("R2 thr", isr_out, 8'h02);
    rd(); chk("R2 msr", isr_out, 8'h00);
    rd(); chk("R2 xch", isr_out, 8'h10);
    rd(); chk("R2 flw", isr_out, 8'h20);
    rd(); chk("R2 none", isr_out, 8'h01);
    flow_sig = 0; tick();
  endtask

  task automatic t_mask();
    src_en = 6'h00; line_err = 1; tick();
    chk("R3 masked line", isr_out, 8'h01);
    src_en = 6'h01; tick();
    chk("R3 enabled line", isr_out, 8'h06);
    line_err = 0; src_en = 6'h3F; tick();
  endtask

  task automatic t_enh();
    enh_en = 0; ev_xon = 1; tick(); ev_xon = 0;
    chk("R4 hidden", isr_out, 8'h01);
    rd(); enh_en = 1; tick();
    chk("R4 shown", isr_out, 8'h10);
    rd(); chk("R4 cleared", isr_out, 8'h01);
  endtask

  task automatic t_read_hidden();
    line_err = 1; ev_thr_empty = 1; tick(); ev_thr_empty = 0;
    rd(); chk("R5 line kept", isr_out, 8'h06);
    line_err = 0; tick();
    chk("R5 thr kept", isr_out, 8'h02);
    rd(); chk("R5 thr cleared", isr_out, 8'h01);
  endtask

  task automatic t_xchar();
    ev_xoff = 1; tick(); ev_xoff = 0;
    chk("R6 xoff code", isr_out, 8'h10);
    chk("R6 xoff last", xoff_last, 1);
    rd(); chk("R6 read clear", isr_out, 8'h01);
    ev_xon = 1; tick(); ev_xon = 0;
    chk("R6 xon last", xoff_last, 0);
    rd();
  endtask

  task automatic t_special();
    ev_special = 1; tick(); ev_special = 0;
    chk("R7 special", isr_out, 8'h10);
    rx_char_done = 1; tick(); rx_char_done = 0;
    chk("R7 auto clear", isr_out, 8'h01);
    ev_special = 1; tick(); ev_special = 0;
    rd(); chk("R7 read clear", isr_out, 8'h01);
  endtask

  task automatic t_flow();
    flow_sig = 1; tick();
    chk("R8 rise", isr_out, 8'h20);
    rd(); tick(); tick();
    chk("R8 level", isr_out, 8'h01);
    flow_sig = 0; tick(); tick();
    chk("R8 fall", isr_out, 8'h01);
    flow_sig = 1; tick();
    chk("R8 rise again", isr_out, 8'h20);
    rd(); flow_sig = 0; tick();
  endtask

  task automatic t_fcr();
    fcr(8'h02);
    chk("R10 no enable", fifo_en, 0);
    chk("R11 gated rst", rx_fifo_rst, 0);
    chk("R9 off bits", isr_out[7:6], 2'b00);
    fcr(8'hC9);
    chk("R10 enable", fifo_en, 1);
    chk("R10 trig", rx_trig, 2'b11);
    chk("R10 blk", blk_mode, 1);
    chk("R9 on bits", isr_out[7:6], 2'b11);
    fcr(8'h43);
    chk("R11 pulse", rx_fifo_rst, 1);
    chk("R10 trig1", rx_trig, 2'b01);
    tick();
    chk("R11 one shot", rx_fifo_rst, 0);
    fcr(8'h8A);
    chk("R10 disable", fifo_en, 0);
    chk("R10 trig kept", rx_trig, 2'b01);
    chk("R10 blk kept", blk_mode, 0);
    tick();
    chk("R11 no pulse", rx_fifo_rst, 0);
  endtask

  task automatic t_irq();
    ev_modem = 1; tick(); ev_modem = 0;
    chk("R12 status", isr_out[0], 0);
    chk("R12 lag", irq, 0);
    tick(); chk("R12 raised", irq, 1);
    rd(); chk("R12 status idle", isr_out[0], 1);
    chk("R12 still high", irq, 1);
    tick(); chk("R12 dropped", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_priority();
    t_mask();
    t_enh();
    t_read_hidden();
    t_xchar();
    t_special();
    t_flow();
    t_fcr();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule